// File: doc/BRIEF.md
# Iterative CORDIC Vector Magnitude Engine

This block computes the length of a complex sample, sqrt(I² + Q²), for envelope detection after a coherent demodulator. It uses no multipliers. A start pulse captures two signed fixed-point inputs. If I is negative, the block negates both components, which moves the vector into the right half-plane. It then applies one micro-rotation per clock. Each micro-rotation is a pair of arithmetic shifts and add/subtract operations, and it drives Q toward zero while the vector settles on the positive I axis.

The I value that remains carries the CORDIC gain of about 1.647. A second sequential pass multiplies it by the reciprocal gain (about 0.60725), one constant bit per clock, using only shifts and adds. The rounded result appears on `mag` together with a one-cycle `done` pulse.

The controller has four states:

- IDLE waits for `start` and moves to ROTATE when `start` is high.
- ROTATE performs ITER micro-rotations and then moves to SCALE.
- SCALE performs 32 shift-add gain steps and then moves to EMIT.
- EMIT registers the result, raises `done` and returns to IDLE.

`busy` is high in every state except IDLE.

Top module: `vmag_cordic_top`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `busy` and `done` are 0 and `mag` is 0.
- R2: A `start` sampled high while `busy` is 0 is accepted: `busy` reads 1 after that clock edge.
- R3: If `start` is accepted at clock edge n, `done` is 1 only in the cycle after edge n+ITER+33, which is edge n+65 with the defaults. It lasts exactly one cycle, and `busy` is 0 in that cycle.
- R4: For any pair of signed 32-bit inputs, in any quadrant, `mag` is an unsigned 32-bit value within 3 LSB of sqrt(I² + Q²).
- R5: The most negative input pair (-2^31, -2^31) does not overflow. It yields about 3037000500, within 3 LSB.
- R6: A `start` pulse or an input change while `busy` is 1 is ignored. The running result and its timing are unaffected, and no extra `done` pulse follows.
- R7: `mag` changes only in a cycle where `done` is 1, and it holds its value between results.
- R8: A zero vector yields exactly 0, and vectors on either axis yield their absolute component value within 3 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new computation; sampled in IDLE only |
| in_i | input | DATA_W | In-phase component, signed |
| in_q | input | DATA_W | Quadrature component, signed |
| busy | output | 1 | High while a computation is in progress |
| done | output | 1 | One-cycle pulse marking a fresh result |
| mag | output | DATA_W | Unsigned magnitude, held until the next result |

## Verification
With the defaults, `busy` is due one edge after the accepting edge, and the result with its `done` pulse is due 65 edges after it. The bench drives inputs on falling edges. It then counts falling edges after the accepting edge and checks `done` to be 0 on every count before 65, 1 on count 65 and 0 again on count 66. At count 66 it also checks that `mag` is unchanged. Expected magnitudes come from a real-valued square root in the bench, compared with a 3 LSB tolerance. A second start is injected mid-run to show that the result and its timing do not move.

// File: rtl/vmag_pkg.sv
package vmag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROTATE,
        ST_SCALE,
        ST_EMIT
    } vmag_state_e;

    // reciprocal CORDIC gain 0.6072529350... as a 32-bit binary fraction
    localparam int GAIN_W = 32;
    localparam logic [GAIN_W-1:0] GAIN_K = 32'h9B74_EDA9;
endpackage

// File: rtl/vmag_fold.sv
module vmag_fold #(
    parameter int DATA_W = 32,
    parameter int W      = 40,
    parameter int GUARD  = 6
) (
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    output logic signed [W-1:0]      x0,
    output logic signed [W-1:0]      y0
);
    logic signed [W-1:0] i_ext;
    logic signed [W-1:0] q_ext;

    always_comb begin
        i_ext = W'(in_i) <<< GUARD;
        q_ext = W'(in_q) <<< GUARD;
        if (in_i[DATA_W-1]) begin
            // half-turn: keeps the vector in the right half-plane
            x0 = -i_ext;
            y0 = -q_ext;
        end else begin
            x0 = i_ext;
            y0 = q_ext;
        end
    end
endmodule

// File: rtl/vmag_microrot.sv
module vmag_microrot #(
    parameter int W     = 40,
    parameter int CNT_W = 6
) (
    input  logic signed [W-1:0] x_cur,
    input  logic signed [W-1:0] y_cur,
    input  logic [CNT_W-1:0]    step,
    output logic signed [W-1:0] x_nxt,
    output logic signed [W-1:0] y_nxt
);
    logic signed [W-1:0] x_sh;
    logic signed [W-1:0] y_sh;

    always_comb begin
        x_sh = x_cur >>> step;
        y_sh = y_cur >>> step;
        if (!y_cur[W-1]) begin
            x_nxt = x_cur + y_sh;
            y_nxt = y_cur - x_sh;
        end else begin
            x_nxt = x_cur - y_sh;
            y_nxt = y_cur + x_sh;
        end
    end
endmodule

// File: rtl/vmag_gain_step.sv
module vmag_gain_step
    import vmag_pkg::*;
#(
    parameter int W     = 40,
    parameter int CNT_W = 6
) (
    input  logic signed [W-1:0] acc_cur,
    input  logic signed [W-1:0] x_fin,
    input  logic [CNT_W-1:0]    step,
    output logic signed [W-1:0] acc_nxt
);
    int                  bit_idx;
    int                  sh_amt;
    logic signed [W-1:0] term;

    always_comb begin
        bit_idx = GAIN_W - 1 - int'(step);
        sh_amt  = int'(step) + 1;
        term    = x_fin >>> sh_amt;
        if (bit_idx >= 0 && GAIN_K[bit_idx[4:0]])
            acc_nxt = acc_cur + term;
        else
            acc_nxt = acc_cur;
    end
endmodule

// File: rtl/vmag_cordic_top.sv
module vmag_cordic_top
    import vmag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ITER   = 32,
    parameter int GUARD  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        mag
);
    localparam int W       = DATA_W + 2 + GUARD;
    localparam int MAX_CNT = (ITER > GAIN_W) ? ITER : GAIN_W;
    localparam int CNT_W   = $clog2(MAX_CNT) + 1;
    localparam logic [CNT_W-1:0] LAST_ROT  = CNT_W'(ITER - 1);
    localparam logic [CNT_W-1:0] LAST_GAIN = CNT_W'(GAIN_W - 1);
    localparam logic signed [W-1:0] HALF_LSB = W'(1) <<< (GUARD - 1);

    vmag_state_e         state_q, state_d;
    logic signed [W-1:0] x_q, y_q, acc_q;
    logic [CNT_W-1:0]    step_q;
    logic signed [W-1:0] x0, y0, x_n, y_n, acc_n, rounded;

    vmag_fold #(.DATA_W(DATA_W), .W(W), .GUARD(GUARD)) u_fold (
        .in_i (in_i),
        .in_q (in_q),
        .x0   (x0),
        .y0   (y0)
    );

    vmag_microrot #(.W(W), .CNT_W(CNT_W)) u_rot (
        .x_cur (x_q),
        .y_cur (y_q),
        .step  (step_q),
        .x_nxt (x_n),
        .y_nxt (y_n)
    );

    vmag_gain_step #(.W(W), .CNT_W(CNT_W)) u_gain (
        .acc_cur (acc_q),
        .x_fin   (x_q),
        .step    (step_q),
        .acc_nxt (acc_n)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ROTATE;
            ST_ROTATE: if (step_q == LAST_ROT) state_d = ST_SCALE;
            ST_SCALE:  if (step_q == LAST_GAIN) state_d = ST_EMIT;
            ST_EMIT:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign rounded = acc_q + HALF_LSB;
    assign busy    = (state_q != ST_IDLE);

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            acc_q  <= '0;
            step_q <= '0;
            done   <= 1'b0;
            mag    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        x_q    <= x0;
                        y_q    <= y0;
                        acc_q  <= '0;
                        step_q <= '0;
                    end
                end
                ST_ROTATE: begin
                    x_q    <= x_n;
                    y_q    <= y_n;
                    step_q <= (step_q == LAST_ROT) ? '0 : step_q + 1'b1;
                end
                ST_SCALE: begin
                    acc_q  <= acc_n;
                    step_q <= step_q + 1'b1;
                end
                ST_EMIT: begin
                    mag  <= DATA_W'(rounded >>> GUARD);
                    done <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vmag_cordic_chk.sv
module vmag_cordic_chk #(
    parameter int DATA_W = 32,
    parameter int ITER   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] mag
);
    localparam int LAT = ITER + 32 + 1;

    int cyc_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cyc_cnt <= 0;
        else if (start && !busy) cyc_cnt <= 0;
        else if (busy)           cyc_cnt <= cyc_cnt + 1;
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && !done));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc_cnt == LAT));

    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done && cyc_cnt < LAT - 1) |=> (busy && !done));

    p_mag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mag) |-> done);
endmodule

bind vmag_cordic_top vmag_cordic_chk #(.DATA_W(DATA_W), .ITER(ITER)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .mag   (mag)
);

// File: tb/test_vmag_cordic_top.sv
module test_vmag_cordic_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int LAT        = 32 + 32 + 1;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     start = 1'b0;
    logic signed [DATA_W-1:0] in_i = '0;
    logic signed [DATA_W-1:0] in_q = '0;
    logic                     busy;
    logic                     done;
    logic [DATA_W-1:0]        mag;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmag_cordic_top i_vmag_cordic_top (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .in_i  (in_i),
        .in_q  (in_q),
        .busy  (busy),
        .done  (done),
        .mag   (mag)
    );

    function automatic real exp_mag(longint a, longint b);
        real ra = real'(a);
        real rb = real'(b);
        return $sqrt(ra * ra + rb * rb);
    endfunction

    task automatic chk_bit(string tag, logic got, logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic chk_mag(string tag, logic [DATA_W-1:0] got, real exp, real tol);
        real diff;
        n_tests++;
        diff = real'(longint'({32'b0, got})) - exp;
        if (diff < 0.0) diff = -diff;
        if (diff > tol) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0.1f", tag, got, exp);
        end
    endtask

    // one computation; optional interfering start at observation 5 (R6)
    task automatic run_one(string tag, int a, int b, bit interfere);
        logic [DATA_W-1:0] res;
        int extra_done;
        @(negedge clk);
        in_i  = a;
        in_q  = b;
        start = 1'b1;
        for (int k = 0; k <= LAT; k++) begin
            @(negedge clk);
            if (k == 0) begin
                start = 1'b0;
                chk_bit({tag, " R2 busy after accept"}, busy, 1'b1);
            end
            if (interfere && k == 5) begin
                start = 1'b1;
                in_i  = 32'sh8000_0000;
                in_q  = 32'sd12345;
            end
            if (interfere && k == 6) start = 1'b0;
            if (k < LAT && done) begin
                n_tests++;
                n_fail++;
                $display("FAIL %s R3: done early at %0d, expected %0d", tag, k, LAT);
            end
        end
        chk_bit({tag, " R3 done on time"}, done, 1'b1);
        chk_bit({tag, " R3 idle with done"}, busy, 1'b0);
        res = mag;
        chk_mag({tag, " R4 magnitude"}, mag, exp_mag(longint'(a), longint'(b)), 3.0);
        @(negedge clk);
        chk_bit({tag, " R3 single pulse"}, done, 1'b0);
        n_tests++;
        if (mag !== res) begin
            n_fail++;
            $display("FAIL %s R7: mag %0d expected held %0d", tag, mag, res);
        end
        if (interfere) begin
            extra_done = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (done) extra_done++;
            end
            n_tests++;
            if (extra_done != 0) begin
                n_fail++;
                $display("FAIL %s R6: %0d extra done pulses, expected 0", tag, extra_done);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20061105));
        repeat (3) @(negedge clk);
        // R1: state held under reset
        chk_bit("R1 busy in reset", busy, 1'b0);
        chk_bit("R1 done in reset", done, 1'b0);
        n_tests++;
        if (mag !== '0) begin
            n_fail++;
            $display("FAIL R1: mag %0d expected 0", mag);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit("R1 busy after release", busy, 1'b0);
        chk_bit("R1 done after release", done, 1'b0);

        // R8: zero and axis vectors
        run_one("R8 zero", 0, 0, 1'b0);
        n_tests++;
        if (mag !== '0) begin
            n_fail++;
            $display("FAIL R8: zero vector mag %0d expected 0", mag);
        end
        run_one("R8 +I axis", 1000000, 0, 1'b0);
        run_one("R8 -I axis", -77777, 0, 1'b0);
        run_one("R8 -Q axis", 0, -5, 1'b0);
        run_one("R8 +Q axis", 0, 2147483647, 1'b0);

        // R4: the four quadrants
        run_one("R4 q1", 3000, 4000, 1'b0);
        run_one("R4 q2", -3000, 4000, 1'b0);
        run_one("R4 q3", -123456789, -987654321, 1'b0);
        run_one("R4 q4", 555555555, -444444444, 1'b0);

        // R5: extreme corners
        run_one("R5 min corner", 32'sh8000_0000, 32'sh8000_0000, 1'b0);
        run_one("R5 max corner", 2147483647, 2147483647, 1'b0);
        run_one("R5 mixed corner", 32'sh8000_0000, 2147483647, 1'b0);

        // R6: start while busy ignored
        run_one("R6 interfere", 1000, 0, 1'b1);

        // R4: random vectors at a spread of scales
        for (int n = 0; n < 40; n++) begin
            int a;
            int b;
            a = int'($urandom()) >>> $urandom_range(0, 30);
            b = int'($urandom()) >>> $urandom_range(0, 30);
            run_one("R4 random", a, b, 1'b0);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule